// File: doc/BRIEF.md
# Keyed Channel Access Lock Controller

This block sits in front of a set of remapped access channels and decides, one request at a time, whether an access may go ahead. Software configures it through a small register interface. A configuration word selects between a free mode and a guarded mode, and holds a secret key and a window length in clock cycles. In the guarded mode a channel must first be opened by writing the key and the channel number to an unlock register. It then stays open for the configured number of cycles, or until one access to it has been granted, whichever ends first. Only one channel can be open at any time.

Every request on the access port gets exactly one answer, one cycle later: grant or abort. A granted access marks the block busy until the downstream transfer engine reports completion. Misuse is recorded in sticky error flags in a status register. Each flag is cleared by writing a one to its bit. While any flag is pending, the unlock register refuses writes, and a single level interrupt output is high.

Register map: address 0 is the configuration word, address 1 is the unlock register, address 2 is the status register. Reads return data one cycle after the read strobe. When no read is made, the read data is zero.

Top module: `chan_key_guard`

## Requirements
- R1: After reset the block is in guarded mode with key 0 and window length 0, all error flags are clear, idle is high and irq is low. The configuration word reads back bit 0 as the mode (1 = free), bits [15:8] as the key and bits [31:16] as the window length, with all other bits reading 0.
- R2: In free mode (configuration bit 0 = 1), a request to any channel is granted when no transfer is in progress, with no unlock needed.
- R3: In guarded mode, an unlock write carries the channel in bits [2:0] and the key in bits [15:8]. If the key matches and the window length N is nonzero, requests to that channel are granted in each of the N cycles after the write cycle. Each request is answered by a grant or an abort in the following cycle.
- R4: If no access is granted within the N cycles, the channel relocks and the expired flag (status bit 0) is set.
- R5: A granted access to the open channel relocks it at once, and no expired flag follows.
- R6: An accepted unlock write for one channel closes any other open channel.
- R7: A request to a channel that is not open, or any request while a transfer is in progress, is aborted and sets the access-denied flag (status bit 1).
- R8: Reading the unlock register returns 0 and sets the unlock-read flag (status bit 2).
- R9: An unlock write with a wrong key, while no flag is pending, closes all channels and sets the bad-key flag (status bit 3).
- R10: An unlock write made while any error flag is set is discarded and sets the refused-unlock flag (status bit 4). The open or closed state of the channels is left as it was.
- R11: The bus-error input sets status bit 5 and the remap-error input sets status bit 6. Writing 1 to a status bit in 6..0 clears it, and a set in the same cycle wins over the clear.
- R12: Idle (the idle output and status bit 8) goes low in the cycle the grant appears and stays low until the cycle after the transfer-done input is seen.
- R13: With a window length of 0, a matching unlock write opens nothing, and a following request is aborted.
- R14: irq is high exactly when any of the status bits 6..0 is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 2 | Register address (0 config, 1 unlock, 2 status) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, valid the cycle after reg_rd |
| acc_req | input | 1 | Channel access request |
| acc_ch | input | CH_W (3) | Requested channel |
| acc_grant | output | 1 | Request of the previous cycle granted |
| acc_abort | output | 1 | Request of the previous cycle aborted |
| xfer_done | input | 1 | Downstream transfer finished |
| bus_err | input | 1 | Downstream bus error pulse |
| remap_err | input | 1 | Downstream bad remap address pulse |
| idle | output | 1 | No granted transfer in progress |
| irq | output | 1 | Any error flag pending |

## Verification
The bench drives requests at both edges of the unlock window: the last cycle, where a design counting one short would abort, and the cycle after, where a design counting one long would still grant and would miss the expired flag. It replaces an open channel with a second unlock and then probes the first channel, which a design without exclusivity would grant. It writes the correct key while a flag is pending and then requests inside what would have been the window, so a design that ignores the refusal shows a grant. It also hits a flag with a set and a clear in the same cycle, which a design giving priority to the clear would lose, and it requests while a transfer is in progress, which a design that forgets busy would grant twice.

// File: rtl/ckg_pkg.sv
package ckg_pkg;
    localparam int DW       = 32;
    localparam int NERR     = 7;
    localparam int KEY_LSB  = 8;
    localparam int CYC_LSB  = 16;
    localparam int IDLE_BIT = 8;

    typedef enum logic [1:0] {
        A_CFG  = 2'd0,
        A_UNLK = 2'd1,
        A_STAT = 2'd2,
        A_NONE = 2'd3
    } reg_addr_e;

    localparam int E_EXPIRED = 0;
    localparam int E_DENIED  = 1;
    localparam int E_PEEK    = 2;
    localparam int E_BADKEY  = 3;
    localparam int E_REFUSED = 4;
    localparam int E_BUS     = 5;
    localparam int E_REMAP   = 6;
endpackage

// File: rtl/ckg_window.sv
module ckg_window #(
    parameter int CH_W  = 3,
    parameter int CYC_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [CH_W-1:0]  load_ch_i,
    input  logic [CYC_W-1:0] load_len_i,
    input  logic             drop_i,
    input  logic             use_i,
    output logic             open_o,
    output logic [CH_W-1:0]  ch_o,
    output logic             expire_o
);
    typedef struct packed {
        logic             open;
        logic [CH_W-1:0]  ch;
        logic [CYC_W-1:0] left;
    } win_t;

    win_t win_d, win_q;

    // window ends this cycle unless replaced, dropped or consumed
    assign expire_o = win_q.open && (win_q.left == CYC_W'(1))
                      && !use_i && !load_i && !drop_i;
    assign open_o   = win_q.open;
    assign ch_o     = win_q.ch;

    always_comb begin
        win_d = win_q;
        if (load_i) begin
            win_d.open = 1'b1;
            win_d.ch   = load_ch_i;
            win_d.left = load_len_i;
        end else if (drop_i || use_i || expire_o) begin
            win_d.open = 1'b0;
            win_d.left = '0;
        end else if (win_q.open) begin
            win_d.left = win_q.left - CYC_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) win_q <= '0;
        else        win_q <= win_d;
    end
endmodule

// File: rtl/ckg_flags.sv
module ckg_flags #(
    parameter int N = 7
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] flags_o
);
    typedef struct packed {
        logic [N-1:0] err;
    } flag_t;

    flag_t fl_d, fl_q;

    always_comb begin
        fl_d     = fl_q;
        fl_d.err = (fl_q.err & ~clr_i) | set_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) fl_q <= '0;
        else        fl_q <= fl_d;
    end

    assign flags_o = fl_q.err;
endmodule

// File: rtl/ckg_port.sv
module ckg_port #(
    parameter int CH_W = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req_i,
    input  logic [CH_W-1:0] ch_i,
    input  logic            free_i,
    input  logic            win_open_i,
    input  logic [CH_W-1:0] win_ch_i,
    input  logic            done_i,
    output logic            grant_o,
    output logic            abort_o,
    output logic            busy_o,
    output logic            use_o,
    output logic            deny_o
);
    typedef struct packed {
        logic grant;
        logic abort;
        logic busy;
    } port_t;

    port_t pt_d, pt_q;
    logic  hit, allow, ok;

    always_comb begin
        hit    = win_open_i && (win_ch_i == ch_i);
        allow  = !pt_q.busy && (free_i || hit);
        ok     = req_i && allow;
        deny_o = req_i && !allow;
        use_o  = ok && hit;

        pt_d       = pt_q;
        pt_d.grant = ok;
        pt_d.abort = deny_o;
        if (ok)          pt_d.busy = 1'b1;
        else if (done_i) pt_d.busy = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) pt_q <= '0;
        else        pt_q <= pt_d;
    end

    assign grant_o = pt_q.grant;
    assign abort_o = pt_q.abort;
    assign busy_o  = pt_q.busy;
endmodule

// File: rtl/chan_key_guard.sv
module chan_key_guard
    import ckg_pkg::*;
#(
    parameter int N_CH  = 8,
    parameter int KEY_W = 8,
    parameter int CYC_W = 16,
    localparam int CH_W = (N_CH > 1) ? $clog2(N_CH) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            reg_wr,
    input  logic            reg_rd,
    input  logic [1:0]      reg_addr,
    input  logic [31:0]     reg_wdata,
    output logic [31:0]     reg_rdata,
    input  logic            acc_req,
    input  logic [CH_W-1:0] acc_ch,
    output logic            acc_grant,
    output logic            acc_abort,
    input  logic            xfer_done,
    input  logic            bus_err,
    input  logic            remap_err,
    output logic            idle,
    output logic            irq
);
    typedef struct packed {
        logic             free;
        logic [KEY_W-1:0] key;
        logic [CYC_W-1:0] len;
        logic [DW-1:0]    rdata;
    } top_t;

    top_t st_d, st_q;

    logic            wr_cfg, wr_unlk, wr_stat, rd_unlk;
    logic            pending, key_ok, load, drop;
    logic [NERR-1:0] err_set, err_clr, flags;
    logic            win_open, expire, use_win, deny, busy;
    logic [CH_W-1:0] win_ch;
    logic            unused_wdata;

    assign unused_wdata = ^reg_wdata;

    always_comb begin
        wr_cfg  = reg_wr && (reg_addr == A_CFG);
        wr_unlk = reg_wr && (reg_addr == A_UNLK);
        wr_stat = reg_wr && (reg_addr == A_STAT);
        rd_unlk = reg_rd && (reg_addr == A_UNLK);

        pending = |flags;
        key_ok  = (reg_wdata[KEY_LSB +: KEY_W] == st_q.key);
        load    = wr_unlk && !pending && key_ok && (st_q.len != '0);
        drop    = wr_unlk && !pending && !load;

        err_set            = '0;
        err_set[E_EXPIRED] = expire;
        err_set[E_DENIED]  = deny;
        err_set[E_PEEK]    = rd_unlk;
        err_set[E_BADKEY]  = wr_unlk && !pending && !key_ok;
        err_set[E_REFUSED] = wr_unlk && pending;
        err_set[E_BUS]     = bus_err;
        err_set[E_REMAP]   = remap_err;
        err_clr            = wr_stat ? reg_wdata[NERR-1:0] : '0;

        st_d       = st_q;
        st_d.rdata = '0;
        if (wr_cfg) begin
            st_d.free = reg_wdata[0];
            st_d.key  = reg_wdata[KEY_LSB +: KEY_W];
            st_d.len  = reg_wdata[CYC_LSB +: CYC_W];
        end
        if (reg_rd) begin
            case (reg_addr)
                A_CFG: begin
                    st_d.rdata[0]                 = st_q.free;
                    st_d.rdata[KEY_LSB +: KEY_W]  = st_q.key;
                    st_d.rdata[CYC_LSB +: CYC_W]  = st_q.len;
                end
                A_STAT: begin
                    st_d.rdata[NERR-1:0] = flags;
                    st_d.rdata[IDLE_BIT] = !busy;
                end
                default: st_d.rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    ckg_window #(.CH_W(CH_W), .CYC_W(CYC_W)) u_window (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (load),
        .load_ch_i  (reg_wdata[CH_W-1:0]),
        .load_len_i (st_q.len),
        .drop_i     (drop),
        .use_i      (use_win),
        .open_o     (win_open),
        .ch_o       (win_ch),
        .expire_o   (expire)
    );

    ckg_port #(.CH_W(CH_W)) u_port (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_i      (acc_req),
        .ch_i       (acc_ch),
        .free_i     (st_q.free),
        .win_open_i (win_open),
        .win_ch_i   (win_ch),
        .done_i     (xfer_done),
        .grant_o    (acc_grant),
        .abort_o    (acc_abort),
        .busy_o     (busy),
        .use_o      (use_win),
        .deny_o     (deny)
    );

    ckg_flags #(.N(NERR)) u_flags (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_i   (err_set),
        .clr_i   (err_clr),
        .flags_o (flags)
    );

    assign reg_rdata = st_q.rdata;
    assign idle      = !busy;
    assign irq       = |flags;
endmodule

// File: rtl/ckg_checker.sv
module ckg_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       reg_rd,
    input logic [1:0] reg_addr,
    input logic       acc_req,
    input logic       acc_grant,
    input logic       acc_abort,
    input logic       xfer_done,
    input logic       idle,
    input logic       irq
);
    // R7
    grant_abort_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(acc_grant && acc_abort));

    // R3
    answer_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc_req |=> (acc_grant || acc_abort));

    // R3
    quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_req |=> !(acc_grant || acc_abort));

    // R14
    abort_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc_abort |-> irq);

    // R12
    grant_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc_grant |-> !idle);

    // R12
    hold_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!idle && !xfer_done) |=> !idle);

    // R8
    peek_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && reg_addr == 2'd1) |=> irq);
endmodule

bind chan_key_guard ckg_checker u_ckg_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_rd    (reg_rd),
    .reg_addr  (reg_addr),
    .acc_req   (acc_req),
    .acc_grant (acc_grant),
    .acc_abort (acc_abort),
    .xfer_done (xfer_done),
    .idle      (idle),
    .irq       (irq)
);

// File: tb/chan_key_guard_test.sv
`timescale 1ns/1ps
module chan_key_guard_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [31:0] reg_wdata = 32'd0;
    logic [31:0] reg_rdata;
    logic        acc_req = 1'b0;
    logic [2:0]  acc_ch = 3'd0;
    logic        acc_grant, acc_abort;
    logic        xfer_done = 1'b0, bus_err = 1'b0, remap_err = 1'b0;
    logic        idle, irq;

    int tests = 0;
    int fails = 0;
    bit run = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    chan_key_guard uut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .acc_req(acc_req), .acc_ch(acc_ch), .acc_grant(acc_grant),
        .acc_abort(acc_abort), .xfer_done(xfer_done), .bus_err(bus_err),
        .remap_err(remap_err), .idle(idle), .irq(irq)
    );

    // behavioural reference model
    int m_free, m_key, m_len, m_open, m_ch, m_left, m_err, m_busy;
    int m_grant, m_abort, m_rdata;

    always @(posedge clk) begin : model
        int g, a, hit, consume, opened, closed, ended, raise, clr, rv, uwr;
        if (!rst_n) begin
            m_free = 0; m_key = 0; m_len = 0; m_open = 0; m_ch = 0; m_left = 0;
            m_err = 0; m_busy = 0; m_grant = 0; m_abort = 0; m_rdata = 0;
        end else begin
            hit = (m_open != 0) && (m_ch == int'(acc_ch));
            g = (acc_req && m_busy == 0 && (m_free != 0 || hit)) ? 1 : 0;
            a = (acc_req && g == 0) ? 1 : 0;
            consume = (g != 0 && hit) ? 1 : 0;
            raise = 0; opened = 0; closed = 0;
            uwr = (reg_wr && reg_addr == 2'd1) ? 1 : 0;
            if (uwr != 0) begin
                if (m_err != 0) raise |= 16;
                else if (int'((reg_wdata >> 8) & 32'hFF) != m_key) begin closed = 1; raise |= 8; end
                else if (m_len == 0) closed = 1;
                else opened = 1;
            end
            ended = (m_open != 0 && m_left == 1 && consume == 0 && opened == 0 && closed == 0) ? 1 : 0;
            if (ended != 0) raise |= 1;
            if (a != 0) raise |= 2;
            if (reg_rd && reg_addr == 2'd1) raise |= 4;
            if (bus_err) raise |= 32;
            if (remap_err) raise |= 64;
            clr = (reg_wr && reg_addr == 2'd2) ? int'(reg_wdata & 32'h7F) : 0;
            rv = 0;
            if (reg_rd && reg_addr == 2'd0) rv = m_free | (m_key << 8) | (m_len << 16);
            if (reg_rd && reg_addr == 2'd2) rv = m_err | ((m_busy == 0 ? 1 : 0) << 8);
            // state updates
            m_err = (m_err & ~clr) | raise;
            if (opened != 0) begin m_open = 1; m_ch = int'(reg_wdata & 32'h7); m_left = m_len; end
            else if (closed != 0 || consume != 0 || ended != 0) begin m_open = 0; m_left = 0; end
            else if (m_open != 0) m_left = m_left - 1;
            if (g != 0) m_busy = 1;
            else if (xfer_done) m_busy = 0;
            m_grant = g; m_abort = a; m_rdata = rv;
            if (reg_wr && reg_addr == 2'd0) begin
                m_free = int'(reg_wdata & 32'h1);
                m_key  = int'((reg_wdata >> 8) & 32'hFF);
                m_len  = int'((reg_wdata >> 16) & 32'hFFFF);
            end
        end
    end

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        tests++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s got %0h exp %0h", tag, got, exp);
        end
    endtask

    // compare against the model every cycle
    always @(negedge clk) begin
        if (run && rst_n) begin
            chk("R3 grant vs model", {31'd0, acc_grant}, m_grant[31:0]);
            chk("R7 abort vs model", {31'd0, acc_abort}, m_abort[31:0]);
            chk("R12 idle vs model", {31'd0, idle}, {31'd0, m_busy == 0});
            chk("R14 irq vs model", {31'd0, irq}, {31'd0, m_err != 0});
            chk("R1 rdata vs model", reg_rdata, m_rdata[31:0]);
        end
    end

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = 32'd0;
    endtask

    task automatic rd(input logic [1:0] a, input logic [31:0] exp, input string tag);
        reg_rd = 1'b1; reg_addr = a;
        @(negedge clk);
        reg_rd = 1'b0;
        chk(tag, reg_rdata, exp);
    endtask

    task automatic acc(input logic [2:0] ch, input logic exp, input string tag);
        acc_req = 1'b1; acc_ch = ch;
        @(negedge clk);
        acc_req = 1'b0;
        chk(tag, {31'd0, acc_grant}, {31'd0, exp});
    endtask

    task automatic done();
        xfer_done = 1'b1;
        @(negedge clk);
        xfer_done = 1'b0;
    endtask

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!finished) begin
            tests++; fails++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin : stim
        tick(3);
        rst_n = 1'b1;
        run = 1;
        // R1 reset state
        chk("R1 idle after reset", {31'd0, idle}, 32'd1);
        chk("R1 irq after reset", {31'd0, irq}, 32'd0);
        rd(2'd0, 32'h0, "R1 config reset");
        rd(2'd2, 32'h100, "R1 status reset");

        // R7 guarded mode, channel closed
        wr(2'd0, 32'h0004_A500);
        acc(3'd2, 1'b0, "R7 closed channel aborted");
        chk("R14 irq after abort", {31'd0, irq}, 32'd1);
        rd(2'd2, 32'h102, "R7 denied flag");
        wr(2'd2, 32'h7F);
        rd(2'd2, 32'h100, "R11 flags cleared");
        chk("R14 irq low when clear", {31'd0, irq}, 32'd0);

        // R3 last cycle of the window, R5 relock after use
        wr(2'd1, 32'h0000_A502);
        tick(3);
        acc(3'd2, 1'b1, "R3 grant on last window cycle");
        done();
        acc(3'd2, 1'b0, "R5 relocked after use");
        rd(2'd2, 32'h102, "R5 no expiry after use");
        wr(2'd2, 32'h7F);

        // R4 expiry
        wr(2'd1, 32'h0000_A502);
        tick(4);
        rd(2'd2, 32'h101, "R4 expired flag");
        acc(3'd2, 1'b0, "R4 closed after window");
        wr(2'd2, 32'h7F);

        // R6 exclusivity
        wr(2'd1, 32'h0000_A501);
        wr(2'd1, 32'h0000_A503);
        acc(3'd1, 1'b0, "R6 previous channel closed");
        wr(2'd2, 32'h7F);
        acc(3'd3, 1'b1, "R6 new channel open");
        done();

        // R9 wrong key
        wr(2'd1, 32'h0000_A504);
        wr(2'd1, 32'h0000_1104);
        rd(2'd2, 32'h108, "R9 bad key flag");
        wr(2'd2, 32'h7F);
        acc(3'd4, 1'b0, "R9 channel closed by bad key");
        wr(2'd2, 32'h7F);

        // R10 refused unlock while a flag is pending
        acc(3'd0, 1'b0, "R7 abort to set a flag");
        wr(2'd1, 32'h0000_A500);
        rd(2'd2, 32'h112, "R10 refused flag");
        wr(2'd2, 32'h7F);
        acc(3'd0, 1'b0, "R10 refused write opened nothing");
        rd(2'd2, 32'h102, "R10 only denied flag");
        wr(2'd2, 32'h7F);

        // R8 unlock register read
        rd(2'd1, 32'h0, "R8 unlock reads zero");
        rd(2'd2, 32'h104, "R8 unlock-read flag");
        wr(2'd2, 32'h7F);

        // R11 external flags and clear priority
        bus_err = 1'b1; tick(1); bus_err = 1'b0;
        remap_err = 1'b1; tick(1); remap_err = 1'b0;
        rd(2'd2, 32'h160, "R11 bus and remap flags");
        wr(2'd2, 32'h20);
        rd(2'd2, 32'h140, "R11 partial clear");
        bus_err = 1'b1;
        wr(2'd2, 32'h7F);
        bus_err = 1'b0;
        rd(2'd2, 32'h120, "R11 set wins over clear");
        wr(2'd2, 32'h7F);

        // R2 free mode, R12 busy tracking
        wr(2'd0, 32'h0004_A501);
        acc(3'd6, 1'b1, "R2 free mode grant");
        chk("R12 idle low on grant", {31'd0, idle}, 32'd0);
        rd(2'd2, 32'h000, "R12 status idle bit low");
        acc(3'd5, 1'b0, "R7 request while busy aborted");
        done();
        chk("R12 idle back after done", {31'd0, idle}, 32'd1);
        wr(2'd2, 32'h7F);
        acc(3'd3, 1'b1, "R2 free mode other channel");
        done();

        // R13 zero-length window
        wr(2'd0, 32'h0000_A500);
        wr(2'd1, 32'h0000_A502);
        acc(3'd2, 1'b0, "R13 zero window grants nothing");
        rd(2'd2, 32'h102, "R13 no bad-key flag");
        wr(2'd2, 32'h7F);

        // R1 configuration layout
        wr(2'd0, 32'hFFFF_FFFF);
        rd(2'd0, 32'hFFFF_FF01, "R1 config field layout");
        wr(2'd0, 32'h0003_5A00);
        rd(2'd0, 32'h0003_5A00, "R1 config readback");

        tick(2);
        finished = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule